// File: doc/BRIEF.md
# Serial Command Word Receiver

This block takes a 16-bit command word from a three-wire serial link: an active-low select, a serial clock and a data line. All three lines are sampled in a fast system clock domain and pass through a short synchroniser. Edges of the serial clock and the select are then detected on the synchronised copies. While select is low, a data bit is shifted in on each falling edge of the serial clock, most significant bit first. A counter tracks how many bits have arrived in the current frame.

When the word is complete, the block sends the parallel word to the logic that decodes it. It raises a one-cycle valid strobe on the earlier of two events: the rising serial clock edge that follows the sixteenth bit, or the release of select. After that strobe the receiver ignores all further serial clocks until select is released and asserted again. If select is released before all sixteen bits have arrived, no word is produced. The block raises a frame-error pulse instead and starts clean on the next frame. The system clock must run at least four times faster than the serial clock.

Top module: `serial_word_rx`

## Requirements
- R1: While reset is asserted and just after it is released, `word_out` is 0, and `word_valid` and `frame_err` are low. The bit counter and the lockout are cleared, so the first frame after reset is received in full.
- R2: While `cs_n` is low, each falling edge of `sclk` captures `sdi` into the word. The first captured bit becomes bit 15 of `word_out` and the sixteenth becomes bit 0.
- R3: Edges of `sclk` while `cs_n` is high shift no data and advance no count. They produce neither strobe, and the next frame is received intact.
- R4: After sixteen bits have arrived, a rising `sclk` edge with `cs_n` still low produces exactly one `word_valid` pulse, and `word_out` holds the received word.
- R5: After sixteen bits have arrived with no rising `sclk` edge since the last one, a rising edge of `cs_n` produces exactly one `word_valid` pulse with the received word.
- R6: If the rising `sclk` edge after the sixteenth bit and the rising edge of `cs_n` fall in the same synchronised cycle, exactly one `word_valid` pulse results.
- R7: After a transfer, further `sclk` edges in the same frame change neither `word_out` nor the strobes. No second `word_valid` appears when `cs_n` then rises.
- R8: A rising edge of `cs_n` with fewer than sixteen bits received (zero included) produces one `frame_err` pulse and no `word_valid`. `word_out` keeps its previous value, and the following frame is counted from zero.
- R9: `word_valid` and `frame_err` each last exactly one system clock cycle and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data, MSB first |
| word_valid | output | 1 | One-cycle strobe: `word_out` holds a new word |
| word_out | output | 16 | Last complete word received |
| frame_err | output | 1 | One-cycle pulse: frame released before 16 bits |

## Verification
The two transfer triggers can land in the same synchronised cycle: the rising serial clock after the sixteenth bit and the release of select. The bench provokes this by driving `sclk` high and `cs_n` high in the same instant. It then checks that only one valid pulse is counted and that the word is intact. The same frames also run with each trigger alone, and with extra clocks after the transfer, so that a second strobe would show up in the pulse count.

// File: rtl/serial_word_rx.sv
module serial_word_rx #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_out,
  output logic              frame_err
);

  localparam int CW = $clog2(WORD_W + 1);
  localparam int S  = SYNC_STAGES;

  logic [S:0]        sclk_q, cs_q, sdi_q;
  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] shreg;
  logic              locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      sdi_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[S-1:0], sclk};
      cs_q   <= {cs_q[S-1:0], cs_n};
      sdi_q  <= {sdi_q[S-1:0], sdi};
    end
  end

  wire sclk_fall = sclk_q[S] & ~sclk_q[S-1];
  wire sclk_rise = ~sclk_q[S] & sclk_q[S-1];
  wire cs_hi     = cs_q[S-1];
  wire cs_rise   = ~cs_q[S] & cs_q[S-1];
  wire sdi_s     = sdi_q[S-1];
  wire full      = (cnt == CW'(WORD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      shreg      <= '0;
      locked     <= 1'b0;
      word_out   <= '0;
      word_valid <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      frame_err  <= 1'b0;
      if (cs_hi) begin
        if (cs_rise && !locked) begin
          if (full) begin
            word_valid <= 1'b1;
            word_out   <= shreg;
          end else begin
            frame_err  <= 1'b1;
          end
        end
        cnt    <= '0;
        locked <= 1'b0;
      end else if (!locked) begin
        if (sclk_fall && !full) begin
          shreg <= {shreg[WORD_W-2:0], sdi_s};
          cnt   <= cnt + CW'(1);
        end else if (sclk_rise && full) begin
          word_valid <= 1'b1;
          word_out   <= shreg;
          locked     <= 1'b1;
        end
      end
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(WORD_W));

  assert_valid_needs_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(cnt) == CW'(WORD_W));

  assert_valid_carries_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> word_out == $past(shreg));

  assert_lockout_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !cs_hi) |=> $stable(shreg) && !word_valid);

  assert_short_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(cnt) < CW'(WORD_W) && $stable(word_out));

  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_valid && frame_err));

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  assert_err_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

endmodule

// File: tb/serial_word_rx_bench.sv
module serial_word_rx_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic        word_valid, frame_err;
  logic [15:0] word_out;

  int checks = 0, failures = 0;
  int n_valid = 0, n_err = 0, n_overlap = 0, n_wide = 0;
  logic [15:0] last_word = '0;
  logic prev_v = 1'b0, prev_e = 1'b0;

  always #5 clk = ~clk;

  serial_word_rx u_serial_word_rx (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .word_valid(word_valid), .word_out(word_out), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (word_valid) begin n_valid++; last_word = word_out; end
      if (frame_err) n_err++;
      if (word_valid && frame_err) n_overlap++;
      if ((word_valid && prev_v) || (frame_err && prev_e)) n_wide++;
    end
    prev_v = word_valid;
    prev_e = frame_err;
  end

  // {word, bit count, extra clocks, end mode: 0 select release, 1 clock rise, 2 both}
  localparam logic [31:0] VEC [9] = '{
    {16'hA5C3, 8'd16, 4'd0, 4'd1},
    {16'h1234, 8'd16, 4'd0, 4'd0},
    {16'hFFFF, 8'd16, 4'd0, 4'd2},
    {16'h8001, 8'd16, 4'd3, 4'd1},
    {16'h0F0F, 8'd5,  4'd0, 4'd1},
    {16'h0000, 8'd0,  4'd0, 4'd0},
    {16'h7E81, 8'd15, 4'd0, 4'd0},
    {16'h3C96, 8'd16, 4'd0, 4'd1},
    {16'h5AA5, 8'd16, 4'd0, 4'd2}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input int extra, input int mode);
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      sdi = w[15 - i];
      wait_clk(4);
      sclk = 1'b0;
      wait_clk(4);
      if (i < nbits - 1) sclk = 1'b1;
    end
    wait_clk(4);
    if (mode == 2) begin
      sclk = 1'b1;
      cs_n = 1'b1;
    end else begin
      if (mode == 1) begin
        sclk = 1'b1;
        wait_clk(4);
        for (int k = 0; k < extra; k++) begin
          sdi = ~sdi;
          sclk = 1'b0;
          wait_clk(4);
          sclk = 1'b1;
          wait_clk(4);
        end
      end
      cs_n = 1'b1;
    end
    wait_clk(8);
    sclk = 1'b1;
    wait_clk(4);
  endtask

  initial begin
    wait_clk(3);
    chk("R1 word_out at reset", 32'(word_out), 32'h0);
    chk("R1 strobes at reset", {word_valid, frame_err}, 32'h0);
    rst_n = 1'b1;
    wait_clk(4);
    chk("R1 strobes after release", {word_valid, frame_err}, 32'h0);

    for (int v = 0; v < 9; v++) begin
      automatic logic [15:0] w = VEC[v][31:16];
      automatic int nb = int'(VEC[v][15:8]);
      automatic int ex = int'(VEC[v][7:4]);
      automatic int md = int'(VEC[v][3:0]);
      automatic int v0 = n_valid, e0 = n_err;
      automatic logic [15:0] prev_word = word_out;
      send(w, nb, ex, md);
      if (nb == 16) begin
        chk(md == 2 ? "R6 single strobe" : (md == 1 ? "R4 strobe count" : "R5 strobe count"),
            n_valid - v0, 1);
        chk(ex > 0 ? "R7 word after extra clocks" : "R2 word value", 32'(last_word), 32'(w));
        chk("R7 no error on full frame", n_err - e0, 0);
      end else begin
        chk("R8 error pulse", n_err - e0, 1);
        chk("R8 no strobe", n_valid - v0, 0);
        chk("R8 word kept", 32'(word_out), 32'(prev_word));
      end
    end

    begin
      automatic int v0 = n_valid, e0 = n_err;
      for (int k = 0; k < 20; k++) begin
        sdi = k[0];
        sclk = 1'b0;
        wait_clk(4);
        sclk = 1'b1;
        wait_clk(4);
      end
      chk("R3 no strobe while deselected", n_valid - v0, 0);
      chk("R3 no error while deselected", n_err - e0, 0);
      send(16'hC3A5, 16, 0, 1);
      chk("R3 next frame intact", 32'(last_word), 32'hC3A5);
      chk("R3 one strobe", n_valid - v0, 1);
    end

    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < 7; i++) begin
      sdi = 1'b1;
      sclk = 1'b0;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
    end
    rst_n = 1'b0;
    cs_n = 1'b1;
    wait_clk(2);
    chk("R1 word_out cleared mid-frame", 32'(word_out), 32'h0);
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);
    begin
      automatic int v0 = n_valid, e0 = n_err;
      send(16'h6B1D, 16, 0, 0);
      chk("R1 first frame after reset", 32'(last_word), 32'h6B1D);
      chk("R1 counter cleared", n_valid - v0, 1);
      chk("R1 no error after reset", n_err - e0, 0);
    end

    chk("R9 strobes never overlap", n_overlap, 0);
    chk("R9 strobes one cycle wide", n_wide, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule